// File: doc/BRIEF.md
# Bipolar Row Waveform Sequencer

This block generates the addressing waveform for one row of a passive-matrix, multi-stable liquid crystal panel. Its output is a 3-bit index that selects one of eight supply rails: index 0 is ground and the other seven are high-voltage rails. Each addressing cycle runs four phases in a fixed order. First comes grey-level selection, then a stabilising bias pulse, then a counter pulse that forces the cell to relax, and last a reset interval at ground. The number of clock ticks in each phase and the rail used in the first three phases are all programmable.

Cycles alternate between positive and negative polarity, so the average voltage across the cell stays close to zero. A negative cycle has the same timing as a positive one, but each rail index is passed through a programmable mirror table that maps it to its opposite-polarity rail. A frame-start strobe begins the sequence with a positive cycle. After that, cycles follow one another without further strobes for as long as the block is enabled. Configuration writes go to a pending copy, which is moved into the working copy only when a cycle begins.

Top module: `bipolar_wave_seq`

## Requirements
- R1: After reset, `level` is 0, `phase` is 0 (idle), `negPolarity` is 0 and `cycleDone` is 0.
- R2: The `phase` codes are 1 for select, 2 for bias, 3 for counter pulse and 4 for reset. A running cycle steps through them in increasing order. Each phase lasts exactly its programmed duration in clock ticks.
- R3: During the reset phase and while idle, `level` is 0 (ground).
- R4: A select, bias or counter phase whose duration is 0 is skipped. A reset phase with duration 0 lasts one tick.
- R5: In a positive cycle, `level` during select, bias and counter equals the rail programmed for that phase.
- R6: In a negative cycle, `level` equals the mirror table entry at the programmed rail. The entry for index 0 is fixed at ground, and writes to its address are ignored. After reset, the mirror table maps each index to itself.
- R7: `cycleDone` is high exactly during the last tick of each reset phase while `enable` is high.
- R8: `negPolarity` toggles at the clock edge that ends a tick with `cycleDone` high, and the next cycle starts at that same edge. This does not apply when a frame start is accepted at that edge.
- R9: While enabled, a `frameStart` is accepted when the block is idle, on the last reset tick, or together with `forceRestart`. An accepted `frameStart` begins a positive cycle at the next edge. Any other `frameStart` is ignored.
- R10: Address map of the write port: 0 to 3 set the durations of select, bias, counter and reset; 4 to 6 set the rails of select, bias and counter; 8 to 15 set the mirror entries for indices 0 to 7. Rails use the low 3 data bits. A write takes effect only at the next cycle start and leaves the cycle in progress unchanged.
- R11: When `enable` is low, the block becomes idle at the next edge and clears `negPolarity`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low forces idle |
| frameStart | input | 1 | Request to start a positive cycle |
| forceRestart | input | 1 | Lets a frame start interrupt a running cycle |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration register address |
| cfgData | input | 16 | Configuration write data |
| level | output | 3 | Selected supply rail index, 0 is ground |
| phase | output | 3 | Current phase code, 0 is idle |
| negPolarity | output | 1 | High during a negative cycle |
| cycleDone | output | 1 | High on the final reset tick |

## Verification
The bench uses the default parameters: 16-bit duration registers and a 3-bit rail index, which gives a full eight-entry mirror table. Durations are programmed from 0 to 7 ticks. This keeps dozens of cycles short enough to reach every skip pattern, including an all-zero cycle that reduces to a single reset tick. Because the cycles are short, frame starts and writes often fall on the last reset tick, where acceptance and the configuration handover both happen. A random phase drives enable, frame starts, forced restarts and writes against the behavioural model.

// File: rtl/bws_pkg.sv
package bws_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_SEL  = 3'd1,
    PH_BIAS = 3'd2,
    PH_CNTR = 3'd3,
    PH_RST  = 3'd4
  } phase_e;

  // Strobes and state the control hands to the datapath
  typedef struct packed {
    logic   loadCfg;
    phase_e phase;
    logic   negPol;
  } ctrlStrobe_t;

endpackage

// File: rtl/bws_ctrl.sv
module bws_ctrl
  import bws_pkg::*;
#(
  parameter int DUR_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  logic                  frameStart,
  input  logic                  forceRestart,
  input  logic [3:0][DUR_W-1:0] effDur,
  output ctrlStrobe_t           strobe,
  output logic                  cycleDone
);

  phase_e            phaseQ;
  logic [DUR_W-1:0]  cntQ;
  logic              negPolQ;

  logic              lastTick, boundary, restart, startCycle;
  logic [2:0]        nonZero;
  phase_e            firstPh, followPh, nextPh;
  logic [DUR_W-1:0]  nextCnt;

  // Earliest driven phase after cur whose duration is non-zero, else reset
  function automatic phase_e nextAfter(input phase_e cur, input logic [2:0] nz);
    phase_e r;
    r = PH_RST;
    for (int k = 2; k >= 0; k--) begin
      if (int'(cur) <= k && nz[k]) r = phase_e'(k + 1);
    end
    return r;
  endfunction

  function automatic logic [DUR_W-1:0] loadCnt(input phase_e p,
                                                input logic [3:0][DUR_W-1:0] d);
    logic [DUR_W-1:0] v;
    if (p == PH_IDLE) return '0;
    v = d[2'(int'(p) - 1)];
    if (v == '0) return '0;
    return v - DUR_W'(1);
  endfunction

  always_comb begin
    for (int k = 0; k < 3; k++) nonZero[k] = (effDur[k] != '0);
  end

  assign lastTick   = (cntQ == '0);
  assign boundary   = enable && (phaseQ == PH_RST) && lastTick;
  assign restart    = enable && frameStart &&
                      ((phaseQ == PH_IDLE) || boundary || forceRestart);
  assign startCycle = restart || boundary;
  assign firstPh    = nextAfter(PH_IDLE, nonZero);
  assign followPh   = nextAfter(phaseQ, nonZero);
  assign nextPh     = startCycle ? firstPh : followPh;
  assign nextCnt    = loadCnt(nextPh, effDur);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ  <= PH_IDLE;
      cntQ    <= '0;
      negPolQ <= 1'b0;
    end else if (!enable) begin
      phaseQ  <= PH_IDLE;
      cntQ    <= '0;
      negPolQ <= 1'b0;
    end else if (startCycle) begin
      phaseQ  <= nextPh;
      cntQ    <= nextCnt;
      negPolQ <= restart ? 1'b0 : ~negPolQ;
    end else if (phaseQ != PH_IDLE) begin
      if (!lastTick) begin
        cntQ <= cntQ - DUR_W'(1);
      end else begin
        phaseQ <= nextPh;
        cntQ   <= nextCnt;
      end
    end
  end

  assign strobe.loadCfg = startCycle;
  assign strobe.phase   = phaseQ;
  assign strobe.negPol  = negPolQ;
  assign cycleDone      = boundary;

endmodule

// File: rtl/bws_datapath.sv
module bws_datapath
  import bws_pkg::*;
#(
  parameter int DUR_W  = 16,
  parameter int LVL_W  = 3,
  parameter int ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [ADDR_W-1:0]     cfgAddr,
  input  logic [DUR_W-1:0]      cfgData,
  input  ctrlStrobe_t           strobe,
  output logic [3:0][DUR_W-1:0] effDur,
  output logic [LVL_W-1:0]      level
);

  localparam int NUM_LVL  = 1 << LVL_W;
  localparam int LVL_BASE = 4;
  localparam int MIR_BASE = 8;

  logic [DUR_W-1:0] pendDur [4];
  logic [DUR_W-1:0] actDur  [4];
  logic [LVL_W-1:0] pendLvl [3];
  logic [LVL_W-1:0] actLvl  [3];
  logic [LVL_W-1:0] pendMir [NUM_LVL];
  logic [LVL_W-1:0] actMir  [NUM_LVL];
  logic [LVL_W-1:0] baseLvl;

  // Pending copy: written at any time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) pendDur[i] <= '0;
      for (int i = 0; i < 3; i++) pendLvl[i] <= '0;
      for (int i = 0; i < NUM_LVL; i++) pendMir[i] <= LVL_W'(i);
    end else if (cfgWe) begin
      for (int i = 0; i < 4; i++)
        if (int'(cfgAddr) == i) pendDur[i] <= cfgData;
      for (int i = 0; i < 3; i++)
        if (int'(cfgAddr) == LVL_BASE + i) pendLvl[i] <= cfgData[LVL_W-1:0];
      for (int i = 1; i < NUM_LVL; i++)
        if (int'(cfgAddr) == MIR_BASE + i) pendMir[i] <= cfgData[LVL_W-1:0];
    end
  end

  // Working copy: refreshed only when a cycle begins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) actDur[i] <= '0;
      for (int i = 0; i < 3; i++) actLvl[i] <= '0;
      for (int i = 0; i < NUM_LVL; i++) actMir[i] <= LVL_W'(i);
    end else if (strobe.loadCfg) begin
      actDur <= pendDur;
      actLvl <= pendLvl;
      actMir <= pendMir;
    end
  end

  generate
    for (genvar g = 0; g < 4; g++) begin : gEff
      assign effDur[g] = strobe.loadCfg ? pendDur[g] : actDur[g];
    end
  endgenerate

  always_comb begin
    level   = '0;
    baseLvl = '0;
    if (strobe.phase == PH_SEL || strobe.phase == PH_BIAS || strobe.phase == PH_CNTR) begin
      baseLvl = actLvl[2'(int'(strobe.phase) - 1)];
      level   = strobe.negPol ? actMir[baseLvl] : baseLvl;
    end
  end

endmodule

// File: rtl/bipolar_wave_seq.sv
module bipolar_wave_seq
  import bws_pkg::*;
#(
  parameter int DUR_W  = 16,
  parameter int LVL_W  = 3,
  parameter int ADDR_W = $clog2(8 + (1 << LVL_W))
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              frameStart,
  input  logic              forceRestart,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DUR_W-1:0]  cfgData,
  output logic [LVL_W-1:0]  level,
  output logic [2:0]        phase,
  output logic              negPolarity,
  output logic              cycleDone
);

  ctrlStrobe_t           strobe;
  logic [3:0][DUR_W-1:0] effDur;

  bws_ctrl #(.DUR_W(DUR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .frameStart(frameStart),
    .forceRestart(forceRestart), .effDur(effDur), .strobe(strobe),
    .cycleDone(cycleDone)
  );

  bws_datapath #(.DUR_W(DUR_W), .LVL_W(LVL_W), .ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .strobe(strobe), .effDur(effDur), .level(level)
  );

  assign phase       = strobe.phase;
  assign negPolarity = strobe.negPol;

endmodule

// File: rtl/bws_checker.sv
module bws_checker #(
  parameter int DUR_W  = 16,
  parameter int LVL_W  = 3,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              frameStart,
  input logic              forceRestart,
  input logic              cfgWe,
  input logic [ADDR_W-1:0] cfgAddr,
  input logic [DUR_W-1:0]  cfgData,
  input logic [LVL_W-1:0]  level,
  input logic [2:0]        phase,
  input logic              negPolarity,
  input logic              cycleDone
);

  AST_RESET_AT_GROUND: assert property (@(posedge clk) disable iff (!rstN)
    phase == 3'd4 |-> level == '0); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    phase == 3'd0 |-> (level == '0 && !cycleDone)); // R3

  AST_DONE_IN_RESET: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |-> (phase == 3'd4 && enable)); // R7

  AST_POL_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (cycleDone && !frameStart) |=> negPolarity != $past(negPolarity)); // R8

  AST_COUNTER_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !frameStart && phase == 3'd3) |=> (phase == 3'd3 || phase == 3'd4)); // R2

  AST_RESTART_POSITIVE: assert property (@(posedge clk) disable iff (!rstN)
    (enable && frameStart && forceRestart) |=> !negPolarity); // R9

  AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (phase == 3'd0 && !negPolarity)); // R11

endmodule

bind bipolar_wave_seq bws_checker #(.DUR_W(DUR_W), .LVL_W(LVL_W), .ADDR_W(ADDR_W)) uChk (.*);

// File: tb/tb_bipolar_wave_seq.sv
module tb_bipolar_wave_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        frameStart = 1'b0;
  logic        forceRestart = 1'b0;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [15:0] cfgData = '0;
  logic [2:0]  level;
  logic [2:0]  phase;
  logic        negPolarity;
  logic        cycleDone;

  int nCmp = 0;
  int nBad = 0;
  bit running = 0;

  // Behavioural reference state
  int pDur[4], aDur[4], pLvl[3], aLvl[3], pMir[8], aMir[8];
  int mPh = 0, mRem = 0, mPol = 0;

  bipolar_wave_seq dut (
    .clk(clk), .rstN(rstN), .enable(enable), .frameStart(frameStart),
    .forceRestart(forceRestart), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .level(level), .phase(phase), .negPolarity(negPolarity), .cycleDone(cycleDone)
  );

  always #4 clk = ~clk;

  function automatic int nextPh(int cur);
    for (int q = cur + 1; q <= 3; q++) if (aDur[q-1] != 0) return q;
    return 4;
  endfunction

  function automatic int remFor(int q);
    if (q == 4) return (aDur[3] == 0) ? 1 : aDur[3];
    return aDur[q-1];
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 4; i++) begin pDur[i] = 0; aDur[i] = 0; end
    for (int i = 0; i < 3; i++) begin pLvl[i] = 0; aLvl[i] = 0; end
    for (int i = 0; i < 8; i++) begin pMir[i] = i; aMir[i] = i; end
    mPh = 0; mRem = 0; mPol = 0;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) begin
      modelReset();
    end else begin
      bit bnd, rs;
      bnd = enable && mPh == 4 && mRem == 1;
      rs  = enable && frameStart && (mPh == 0 || bnd || forceRestart);
      if (!enable) begin
        mPh = 0; mRem = 0; mPol = 0;
      end else if (rs || bnd) begin
        aDur = pDur; aLvl = pLvl; aMir = pMir;
        mPol = rs ? 0 : 1 - mPol;
        mPh  = nextPh(0);
        mRem = remFor(mPh);
      end else if (mPh != 0) begin
        if (mRem > 1) mRem--;
        else begin mPh = nextPh(mPh); mRem = remFor(mPh); end
      end
      if (cfgWe) begin
        int a;
        a = int'(cfgAddr);
        if (a < 4) pDur[a] = int'(cfgData);
        else if (a >= 4 && a <= 6) pLvl[a-4] = int'(cfgData[2:0]);
        else if (a >= 9) pMir[a-8] = int'(cfgData[2:0]);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (running) begin
      int eLvl, b;
      eLvl = 0;
      if (mPh >= 1 && mPh <= 3) begin
        b = aLvl[mPh-1];
        eLvl = mPol ? aMir[b] : b;
      end
      if (mPh == 4 || mPh == 0) chk("R3 level at ground", int'(level), eLvl);
      else if (mPol != 0)       chk("R6 mirrored level", int'(level), eLvl);
      else                      chk("R5 R10 positive level", int'(level), eLvl);
      chk("R2 R4 R9 R11 phase code", int'(phase), mPh);
      chk("R8 polarity", int'(negPolarity), mPol);
      chk("R7 done pulse", int'(cycleDone), (enable && mPh == 4 && mRem == 1) ? 1 : 0);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 4'(a); cfgData = 16'(d);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic pulseStart(bit force_);
    @(negedge clk);
    frameStart = 1'b1; forceRestart = force_;
    @(negedge clk);
    frameStart = 1'b0; forceRestart = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    nBad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    running = 1;
    @(negedge clk); #3;
    // R1 reset state
    chk("R1 level", int'(level), 0);
    chk("R1 phase", int'(phase), 0);
    chk("R1 polarity", int'(negPolarity), 0);
    chk("R1 done", int'(cycleDone), 0);

    // R10 programming through the address map
    wr(0, 2); wr(1, 3); wr(2, 1); wr(3, 2);
    wr(4, 5); wr(5, 6); wr(6, 2);
    for (int i = 1; i < 8; i++) wr(8 + i, 8 - i);
    wr(8, 5);                       // R6 ignored write to entry 0
    enable = 1'b1;
    pulseStart(0);                  // R9 start from idle
    idle(30);
    pulseStart(0);                  // R9 ignored mid-cycle
    idle(5);
    wr(4, 3); wr(1, 0);             // R10 deferred until cycle start
    idle(20);
    pulseStart(1);                  // R9 forced restart
    idle(20);
    wr(3, 0); wr(0, 0); wr(2, 0);   // R4 skips and minimum reset
    idle(20);
    wr(1, 0);
    idle(12);
    enable = 1'b0;                  // R11
    idle(4);
    enable = 1'b1;
    wr(0, 1); wr(1, 2); wr(2, 3); wr(3, 1);
    pulseStart(0);
    idle(30);

    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      enable       = ($urandom % 25) != 0;
      frameStart   = ($urandom % 8) == 0;
      forceRestart = ($urandom % 4) == 0;
      cfgWe        = ($urandom % 5) == 0;
      cfgAddr      = 4'($urandom % 16);
      cfgData      = 16'($urandom % 8);
    end
    @(negedge clk);
    cfgWe = 1'b0; frameStart = 1'b0; forceRestart = 1'b0;
    idle(3);
    running = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule